// File: doc/BRIEF.md
# Arithmetic, Logic and Shift Unit

This block is a purely combinational datapath element. It produces one N-bit result from two N-bit operands, `a_i` and `b_i`. A four-bit operation select and a carry input choose the operation. The unit contains three sections that compute in parallel, and the upper two select bits choose which section drives the result.

The arithmetic section is an adder. Its second operand can be zero, B, the complement of B, or all ones, and the carry input is added in. Together these give transfer, increment, add, add with carry, subtract, subtract with borrow and decrement. The logic section offers AND, OR, XOR and complement of A. The shift section moves A by one position in either direction and takes the vacated bit from a dedicated serial input. The carry out reports the adder carry for arithmetic operations only. The block has no clock and holds no state.

Top module: `alsu_core`

## Requirements
- R1: When `sel_i[3:2]` is 00, `f_o` equals (A + Y + `cin_i`) mod 2^N. Y is all zeros for `sel_i[1:0]`=00, B for 01, the bitwise complement of B for 10, and all ones for 11.
- R2: When `sel_i[3:2]` is 00, `cout_o` is the carry out of the top bit of the R1 sum, which is bit N of A + Y + `cin_i`.
- R3: With `sel_i`=0011, `cin_i`=0 gives A−1 and `cin_i`=1 gives A unchanged. With `sel_i`=0000, `cin_i`=0 gives A unchanged and `cin_i`=1 gives A+1, and all-ones A wraps to zero with `cout_o`=1.
- R4: With `sel_i`=0010 and `cin_i`=1, `f_o` is the two's-complement difference A−B and `cout_o` is 1 exactly when A ≥ B unsigned. With `cin_i`=0, the result is A−B−1.
- R5: When `sel_i[3:2]` is 01, `f_o` is A AND B for `sel_i[1:0]`=00, A OR B for 01, A XOR B for 10, and NOT A for 11. `cin_i` has no effect.
- R6: When `sel_i[3:2]` is 10, `f_o[i]` = `a_i[i+1]` for i < N−1 and `f_o[N-1]` = `shr_in_i`. `sel_i[1:0]` and `cin_i` have no effect.
- R7: When `sel_i[3:2]` is 11, `f_o[i]` = `a_i[i-1]` for i > 0 and `f_o[0]` = `shl_in_i`. `sel_i[1:0]` and `cin_i` have no effect.
- R8: `cout_o` is 0 whenever `sel_i[3:2]` is not 00.
- R9: The outputs follow a change of the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand, and the source for shifts and transfers |
| b_i | input | N | Second operand |
| sel_i | input | 4 | Operation select: [3:2] picks the section, [1:0] picks the function |
| cin_i | input | 1 | Carry input to the adder |
| shr_in_i | input | 1 | Bit shifted into the top position on a right shift |
| shl_in_i | input | 1 | Bit shifted into bit 0 on a left shift |
| f_o | output | N | Result |
| cout_o | output | 1 | Adder carry out; zero outside arithmetic operations |

## Verification
The hardest cases to reach are the ones where the carry input changes the meaning of a code. In decrement with carry-in 1, the full carry ripples through every bit, and the result is A again with carry out 1. In transfer with carry-in 1, the result wraps from all ones to zero. Random operands almost never hit all-zero or all-ones A in these two codes. The stimulus therefore sweeps every select and carry combination over a fixed set of edge operands (zero, all ones, lone top bit, lone bottom bit, alternating bits), and adds named directed vectors for decrement of zero, increment of all ones and both signs of subtraction. Each vector is compared against a behavioural model in the bench.

// File: rtl/alsu_core.sv
`timescale 1ns/1ps
module alsu_core #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [3:0]   sel_i,
  input  logic         cin_i,
  input  logic         shr_in_i,
  input  logic         shl_in_i,
  output logic [N-1:0] f_o,
  output logic         cout_o
);

  localparam logic [1:0] SEC_ARITH = 2'b00;
  localparam logic [1:0] SEC_LOGIC = 2'b01;
  localparam logic [1:0] SEC_SHR   = 2'b10;
  localparam logic [1:0] SEC_SHL   = 2'b11;

  logic [1:0]   sec;
  logic [1:0]   fn;
  logic [N-1:0] y;
  logic [N:0]   c;
  logic [N-1:0] sum;
  logic [N-1:0] lgc;
  logic [N-1:0] shr;
  logic [N-1:0] shl;

  assign sec = sel_i[3:2];
  assign fn  = sel_i[1:0];

  always_comb begin
    unique case (fn)
      2'b00:   y = '0;
      2'b01:   y = b_i;
      2'b10:   y = ~b_i;
      default: y = '1;
    endcase
  end

  assign c[0] = cin_i;
  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum[i]   = a_i[i] ^ y[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & y[i]) | (c[i] & (a_i[i] ^ y[i]));
  end

  always_comb begin
    unique case (fn)
      2'b00:   lgc = a_i & b_i;
      2'b01:   lgc = a_i | b_i;
      2'b10:   lgc = a_i ^ b_i;
      default: lgc = ~a_i;
    endcase
  end

  assign shr = {shr_in_i, a_i[N-1:1]};
  assign shl = {a_i[N-2:0], shl_in_i};

  always_comb begin
    unique case (sec)
      SEC_ARITH: f_o = sum;
      SEC_LOGIC: f_o = lgc;
      SEC_SHR:   f_o = shr;
      default:   f_o = shl;
    endcase
  end

  assign cout_o = (sec == SEC_ARITH) & c[N];

  always_comb begin
    if (sec == SEC_ARITH) begin
      // R1
      arith_sum_chk: assert ({cout_o, f_o} ==
                             ({1'b0, a_i} + {1'b0, y} + (N+1)'(cin_i)));
    end
    if (sel_i == 4'b0010 && cin_i) begin
      // R4
      sub_inverse_chk: assert (N'(f_o + b_i) == a_i);
    end
    if (sel_i == 4'b0111) begin
      // R5
      not_a_chk: assert (f_o == ~a_i && !cout_o);
    end
    if (sec == SEC_SHR) begin
      // R6
      shr_path_chk: assert (f_o[N-1] == shr_in_i && f_o[N-2:0] == a_i[N-1:1]);
    end
    if (sec == SEC_SHL) begin
      // R7
      shl_path_chk: assert (f_o[0] == shl_in_i && f_o[N-1:1] == a_i[N-2:0]);
    end
  end

endmodule

// File: tb/tb_alsu_core.sv
`timescale 1ns/1ps
module tb_alsu_core;
  localparam int N = 8;
  localparam logic [N-1:0] ONES = '1;

  logic clk = 0;
  always #10 clk = ~clk;

  logic [N-1:0] a, b;
  logic [3:0]   sel;
  logic         cin, ir, il;
  logic [N-1:0] f;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  alsu_core #(.N(N)) dut (
    .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin),
    .shr_in_i(ir), .shl_in_i(il), .f_o(f), .cout_o(cout)
  );

  function automatic logic [N:0] model(logic [N-1:0] ma, logic [N-1:0] mb,
                                       logic [3:0] ms, logic mc, logic mr, logic ml);
    int unsigned av, bv, yv, s, r;
    av = ma; bv = mb;
    case (ms[3:2])
      2'b00: begin
        case (ms[1:0])
          2'b00: yv = 0;
          2'b01: yv = bv;
          2'b10: yv = (~bv) & ((1 << N) - 1);
          default: yv = (1 << N) - 1;
        endcase
        s = av + yv + mc;
        return (N+1)'(s);
      end
      2'b01: begin
        case (ms[1:0])
          2'b00: r = av & bv;
          2'b01: r = av | bv;
          2'b10: r = av ^ bv;
          default: r = ~av;
        endcase
        return {1'b0, N'(r)};
      end
      2'b10: return {1'b0, N'((av >> 1) | (int'(mr) << (N - 1)))};
      default: return {1'b0, N'((av << 1) | ml)};
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h sel=%b cin=%b)",
               tag, got, exp, a, b, sel, cin);
    end
  endtask

  task automatic apply(logic [N-1:0] ta, logic [N-1:0] tb, logic [3:0] ts,
                       logic tc, logic tr, logic tl);
    logic [N:0] e;
    @(negedge clk);
    a = ta; b = tb; sel = ts; cin = tc; ir = tr; il = tl;
    #5;
    e = model(ta, tb, ts, tc, tr, tl);
    case (ts[3:2])
      2'b00: begin check("R1", f, e[N-1:0]); check("R2", N'(cout), N'(e[N])); end
      2'b01: begin check("R5", f, e[N-1:0]); check("R8", N'(cout), 0); end
      2'b10: begin check("R6", f, e[N-1:0]); check("R8", N'(cout), 0); end
      default: begin check("R7", f, e[N-1:0]); check("R8", N'(cout), 0); end
    endcase
  endtask

  task automatic expect_pair(string tag, logic [N-1:0] ef, logic ec);
    check(tag, f, ef);
    check(tag, N'(cout), N'(ec));
  endtask

  logic [N-1:0] edges [6];
  logic [N-1:0] ref_f;

  initial begin
    a = 0; b = 0; sel = 0; cin = 0; ir = 0; il = 0;
    edges[0] = '0; edges[1] = ONES; edges[2] = {1'b1, {(N-1){1'b0}}};
    edges[3] = N'(1); edges[4] = {(N/2){2'b01}}; edges[5] = {(N/2){2'b10}};

    @(negedge clk); #5;
    expect_pair("R1 idle zero", '0, 0);

    // R3 corner cases
    apply(N'(0), N'(0), 4'b0011, 0, 0, 0); expect_pair("R3 dec zero", ONES, 0);
    apply(N'(5), N'(0), 4'b0011, 0, 0, 0); expect_pair("R3 dec", N'(4), 1);
    apply(N'(5), N'(0), 4'b0011, 1, 0, 0); expect_pair("R3 dec+cin transfer", N'(5), 1);
    apply(ONES,  N'(0), 4'b0000, 1, 0, 0); expect_pair("R3 inc wrap", N'(0), 1);
    apply(N'(9), N'(0), 4'b0000, 0, 0, 0); expect_pair("R3 transfer", N'(9), 0);
    // R4 subtraction
    apply(N'(3), N'(5), 4'b0010, 1, 0, 0); expect_pair("R4 sub neg", N'(-2), 0);
    apply(N'(5), N'(3), 4'b0010, 1, 0, 0); expect_pair("R4 sub pos", N'(2), 1);
    apply(N'(7), N'(7), 4'b0010, 1, 0, 0); expect_pair("R4 sub equal", N'(0), 1);
    apply(N'(5), N'(3), 4'b0010, 0, 0, 0); expect_pair("R4 sub borrow", N'(1), 1);

    // R5 R6 R7: cin and unused selects have no effect
    apply(8'hC3, 8'h5A, 4'b0110, 0, 0, 0); ref_f = f;
    apply(8'hC3, 8'h5A, 4'b0110, 1, 1, 1); check("R5 cin ignored", f, ref_f);
    apply(8'hC3, 8'h00, 4'b1000, 0, 1, 0); ref_f = f;
    for (int k = 1; k < 8; k++) begin
      apply(8'hC3, 8'hFF, {2'b10, 2'(k)}, k[2], 1, 0);
      check("R6 select ignored", f, ref_f);
    end
    apply(8'hC3, 8'h00, 4'b1100, 0, 0, 1); ref_f = f;
    for (int k = 1; k < 8; k++) begin
      apply(8'hC3, 8'hFF, {2'b11, 2'(k)}, k[2], 0, 1);
      check("R7 select ignored", f, ref_f);
    end

    // R9 output follows inputs mid-cycle
    @(posedge clk); #3;
    a = 8'h21; b = 8'h10; sel = 4'b0001; cin = 0;
    #1; check("R9 no clock", f, 8'h31);

    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            apply(edges[i], edges[j], 4'(s), c[0], i[0], j[0]);

    for (int n = 0; n < 3000; n++)
      apply(N'($urandom), N'($urandom), 4'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule